// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Access Sequencer

This block is the host-side engine for an asynchronous external bus on which address and data share the same 32 wires. It takes one single access at a time, read or write, from a valid/ready request port. Each access runs for a programmed number of clock ticks. The clock cycle after a request is accepted is tick 0. Four active-low strobes are generated from tick windows, all counted from tick 0: chip select, address valid, write enable and output enable.

The bus carries the address first and switches to write data at a programmed tick. On reads the host releases the bus at that tick. Read data is captured at a programmed sample tick and returned with a one-cycle response pulse. There is no wait input and no direction pin, so the programmed counts alone set how long an access lasts. After each access the block inserts a programmable idle gap. A held request therefore starts exactly one access every cycle-time-plus-gap ticks.

Timing values come in on configuration ports and are latched when a request is accepted. Typical values for a slow device at a fast bus clock are:

- chip select low over ticks 1 to 9 (deassert value 10)
- address valid over ticks 2 to 4
- write enable or output enable over ticks 6 to 8
- data phase from tick 5
- sample at tick 8
- cycle length 11
- gap 2

Top module: `mux_bus_sequencer`

## Requirements
- R1: After reset, cs_n, adv_n, we_n and oe_n are 1, bus_oe is 0, rsp_valid is 0 and req_ready is 1.
- R2: Tick 0 is the cycle after the clock edge that accepts a request. cs_n and adv_n are 0 exactly on ticks t with on <= t < off, using their own on/off values. When on equals off, the strobe never asserts.
- R3: we_n follows its window only on writes (req_write=1) and oe_n only on reads (req_write=0). The other one of the pair stays 1 for the whole access.
- R4: During an access, bus_out carries {zeros, req_addr} on ticks below cfg_data_at. On writes it then carries req_wdata from tick cfg_data_at through the last tick, with bus_oe=1 on every tick. On reads bus_oe is 1 only on ticks below cfg_data_at.
- R5: On reads, the value of bus_in during tick cfg_sample_at is returned on rsp_rdata.
- R6: rsp_valid is 1 for exactly one cycle: the cycle right after tick cfg_cycle-1. It is 0 during the last tick.
- R7: While req_valid is held high, consecutive accesses start exactly cfg_cycle + cfg_gap cycles apart.
- R8: cfg_err is 1 when cfg_cycle is 0, when any deassert value or cfg_data_at exceeds cfg_cycle, or when cfg_sample_at >= cfg_cycle. While cfg_err is 1, no request is accepted and all strobes stay 1.
- R9: Configuration values are latched at acceptance. Changes on the configuration ports during an access do not alter that access.
- R10: Outside an access (idle or gap), all strobes are 1 and bus_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_cs_on | input | 5 | Chip select assert tick |
| cfg_cs_off | input | 5 | Chip select deassert tick |
| cfg_adv_on | input | 5 | Address valid assert tick |
| cfg_adv_off | input | 5 | Address valid deassert tick |
| cfg_we_on | input | 5 | Write enable assert tick |
| cfg_we_off | input | 5 | Write enable deassert tick |
| cfg_oe_on | input | 5 | Output enable assert tick |
| cfg_oe_off | input | 5 | Output enable deassert tick |
| cfg_data_at | input | 5 | Tick where the bus leaves the address phase |
| cfg_sample_at | input | 5 | Read sample tick |
| cfg_cycle | input | 5 | Access length in ticks |
| cfg_gap | input | 5 | Idle ticks after each access |
| cfg_err | output | 1 | Configuration is inconsistent |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 28 | Byte address in the 256 MB window |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | A request can be accepted this cycle |
| rsp_valid | output | 1 | Access finished (one-cycle pulse) |
| rsp_rdata | output | 32 | Read data |
| bus_out | output | 32 | Value driven on the shared bus |
| bus_oe | output | 1 | Host drives the shared bus |
| bus_in | input | 32 | Value seen on the shared bus |
| cs_n | output | 1 | Chip select, active low |
| adv_n | output | 1 | Address valid, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |

## Verification
The bench sweeps cycle lengths from 3 to 8 and gaps from 0 to 2 for both directions. It checks every strobe and the bus on every tick against windows computed from the programmed values. Such a sweep reveals an off-by-one at either window edge, or a data phase that starts a tick early. A zero-length window and a sample on the last tick are included. A design that off-by-ones these would pulse a strobe or return data from the wrong tick. The start-to-start spacing is measured with the request held, both with and without a gap. A sequencer that lost or added an idle tick at the hand-over would show up there. Illegal configurations are held against a pending request, and the configuration ports are disturbed in mid-access, to catch a block that starts anyway or follows live values.

// File: rtl/mbs_pkg.sv
// Package: shared types for the multiplexed bus sequencer.
// Assumes tick values fit in MBS_TICK_W bits.
package mbs_pkg;
    localparam int unsigned MBS_TICK_W = 5;
    localparam int unsigned NSTROBE    = 4;
    localparam int unsigned STB_CS     = 0;
    localparam int unsigned STB_ADV    = 1;
    localparam int unsigned STB_WE     = 2;
    localparam int unsigned STB_OE     = 3;

    typedef logic [MBS_TICK_W-1:0] tick_t;

    typedef struct packed {
        tick_t cs_on;
        tick_t cs_off;
        tick_t adv_on;
        tick_t adv_off;
        tick_t we_on;
        tick_t we_off;
        tick_t oe_on;
        tick_t oe_off;
        tick_t data_at;
        tick_t sample_at;
        tick_t cycle;
        tick_t gap;
    } timing_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_GAP    = 2'd2
    } seq_state_e;
endpackage

// File: rtl/mbs_sequencer.sv
// Module: access sequencer. Accepts requests, latches the timing set,
// counts access ticks and gap ticks, and raises the completion pulse.
// Assumes configuration ports may change at any time; only the latched
// copy is used during an access.
module mbs_sequencer
    import mbs_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  timing_t cfg_live,
    input  logic    req_valid,
    input  logic    req_write,
    output logic    cfg_err,
    output logic    req_ready,
    output logic    accept,
    output logic    active,
    output logic    write_q,
    output tick_t   tick,
    output tick_t   stb_on  [NSTROBE],
    output tick_t   stb_off [NSTROBE],
    output tick_t   data_at,
    output tick_t   sample_at,
    output logic    rsp_valid
);
    seq_state_e state;
    timing_t    cfg_q;
    tick_t      gcnt;
    logic       last_tick;
    logic       gap_end;

    // Legality check of the live configuration.
    always_comb begin
        cfg_err = (cfg_live.cycle == '0)
               || (cfg_live.cs_off  > cfg_live.cycle)
               || (cfg_live.adv_off > cfg_live.cycle)
               || (cfg_live.we_off  > cfg_live.cycle)
               || (cfg_live.oe_off  > cfg_live.cycle)
               || (cfg_live.data_at > cfg_live.cycle)
               || (cfg_live.sample_at >= cfg_live.cycle);
    end

    // Hand-over points and the request handshake.
    always_comb begin
        active    = (state == ST_ACTIVE);
        last_tick = active && (tick == cfg_q.cycle - 1'b1);
        gap_end   = (state == ST_GAP) && (gcnt == cfg_q.gap - 1'b1);
        req_ready = (state == ST_IDLE) || gap_end
                 || (last_tick && (cfg_q.gap == '0));
        accept    = req_valid && req_ready && !cfg_err;
    end

    // Export the latched windows in strobe order.
    always_comb begin
        stb_on[STB_CS]   = cfg_q.cs_on;
        stb_off[STB_CS]  = cfg_q.cs_off;
        stb_on[STB_ADV]  = cfg_q.adv_on;
        stb_off[STB_ADV] = cfg_q.adv_off;
        stb_on[STB_WE]   = cfg_q.we_on;
        stb_off[STB_WE]  = cfg_q.we_off;
        stb_on[STB_OE]   = cfg_q.oe_on;
        stb_off[STB_OE]  = cfg_q.oe_off;
        data_at          = cfg_q.data_at;
        sample_at        = cfg_q.sample_at;
    end

    // State, tick counters, configuration latch and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            tick      <= '0;
            gcnt      <= '0;
            cfg_q     <= '0;
            write_q   <= 1'b0;
            rsp_valid <= 1'b0;
        end else begin
            rsp_valid <= last_tick;
            if (accept) begin
                state   <= ST_ACTIVE;
                tick    <= '0;
                cfg_q   <= cfg_live;
                write_q <= req_write;
            end else begin
                case (state)
                    ST_ACTIVE: begin
                        if (last_tick) begin
                            state <= (cfg_q.gap == '0) ? ST_IDLE : ST_GAP;
                            gcnt  <= '0;
                        end else begin
                            tick <= tick + 1'b1;
                        end
                    end
                    ST_GAP: begin
                        if (gap_end) state <= ST_IDLE;
                        else         gcnt  <= gcnt + 1'b1;
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    AST_TICK_IN_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (tick < cfg_q.cycle)); // R2
    AST_ERR_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && state == ST_IDLE) |=> (state == ST_IDLE)); // R8
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && tick != '0) |-> $stable(cfg_q)); // R9
endmodule

// File: rtl/mbs_strobes.sv
// Module: strobe decoder. Each active-low strobe is low while the tick
// lies in [on, off). The write enable is gated by a write access, the
// output enable by a read access.
// Assumes tick is valid only while active is high.
module mbs_strobes
    import mbs_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  active,
    input  logic  write_q,
    input  tick_t tick,
    input  tick_t stb_on  [NSTROBE],
    input  tick_t stb_off [NSTROBE],
    output logic  cs_n,
    output logic  adv_n,
    output logic  we_n,
    output logic  oe_n
);
    logic [NSTROBE-1:0] en;
    logic [NSTROBE-1:0] stb_n;

    // Per-strobe direction qualifier.
    always_comb begin
        en          = '1;
        en[STB_WE]  = write_q;
        en[STB_OE]  = !write_q;
    end

    for (genvar i = 0; i < NSTROBE; i++) begin : g_stb
        // Window compare for one strobe.
        always_comb begin
            stb_n[i] = !(active && en[i]
                         && (tick >= stb_on[i]) && (tick < stb_off[i]));
        end
    end

    // Map the vector onto named pins.
    always_comb begin
        cs_n  = stb_n[STB_CS];
        adv_n = stb_n[STB_ADV];
        we_n  = stb_n[STB_WE];
        oe_n  = stb_n[STB_OE];
    end

    AST_WE_OE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (we_n || oe_n)); // R3
    AST_IDLE_STROBES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (cs_n && adv_n && we_n && oe_n)); // R10
endmodule

// File: rtl/mbs_busmux.sv
// Module: shared bus datapath. Latches address and write data at
// acceptance, drives the address phase then the data phase, releases
// the bus for read data, and captures it at the sample tick.
// Assumes ADDR_W <= DATA_W; the address is zero-extended.
module mbs_busmux
    import mbs_pkg::*;
#(
    parameter int unsigned ADDR_W = 28,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              active,
    input  logic              write_q,
    input  tick_t             tick,
    input  tick_t             data_at,
    input  tick_t             sample_at,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic [DATA_W-1:0] rdata
);
    localparam int unsigned PAD_W = DATA_W - ADDR_W;

    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              data_phase;

    // Latch the request payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    // Phase select and bus drive.
    always_comb begin
        data_phase = (tick >= data_at);
        bus_oe     = active && (write_q || !data_phase);
        if (!bus_oe)         bus_out = '0;
        else if (data_phase) bus_out = wdata_q;
        else                 bus_out = {{PAD_W{1'b0}}, addr_q};
    end

    // Capture read data at the sample tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (active && !write_q && tick == sample_at) begin
            rdata <= bus_in;
        end
    end

    AST_BUS_RELEASED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !bus_oe); // R10
    AST_PAYLOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (active && tick != '0) |-> ($stable(addr_q) && $stable(wdata_q))); // R4
endmodule

// File: rtl/mux_bus_sequencer.sv
// Module: top of the multiplexed address/data bus access sequencer.
// Assumes a single device, no wait input, one access in flight.
module mux_bus_sequencer
    import mbs_pkg::*;
#(
    parameter int unsigned ADDR_W = 28,
    parameter int unsigned DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [MBS_TICK_W-1:0] cfg_cs_on,
    input  logic [MBS_TICK_W-1:0] cfg_cs_off,
    input  logic [MBS_TICK_W-1:0] cfg_adv_on,
    input  logic [MBS_TICK_W-1:0] cfg_adv_off,
    input  logic [MBS_TICK_W-1:0] cfg_we_on,
    input  logic [MBS_TICK_W-1:0] cfg_we_off,
    input  logic [MBS_TICK_W-1:0] cfg_oe_on,
    input  logic [MBS_TICK_W-1:0] cfg_oe_off,
    input  logic [MBS_TICK_W-1:0] cfg_data_at,
    input  logic [MBS_TICK_W-1:0] cfg_sample_at,
    input  logic [MBS_TICK_W-1:0] cfg_cycle,
    input  logic [MBS_TICK_W-1:0] cfg_gap,
    output logic                  cfg_err,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    output logic                  req_ready,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic [DATA_W-1:0]     bus_out,
    output logic                  bus_oe,
    input  logic [DATA_W-1:0]     bus_in,
    output logic                  cs_n,
    output logic                  adv_n,
    output logic                  we_n,
    output logic                  oe_n
);
    timing_t cfg_live;
    logic    accept;
    logic    active;
    logic    write_q;
    tick_t   tick;
    tick_t   stb_on  [NSTROBE];
    tick_t   stb_off [NSTROBE];
    tick_t   data_at;
    tick_t   sample_at;

    // Gather the configuration ports into one record.
    always_comb begin
        cfg_live = '{cs_on: cfg_cs_on, cs_off: cfg_cs_off,
                     adv_on: cfg_adv_on, adv_off: cfg_adv_off,
                     we_on: cfg_we_on, we_off: cfg_we_off,
                     oe_on: cfg_oe_on, oe_off: cfg_oe_off,
                     data_at: cfg_data_at, sample_at: cfg_sample_at,
                     cycle: cfg_cycle, gap: cfg_gap};
    end

    mbs_sequencer u_seq (
        .clk(clk), .rst_n(rst_n), .cfg_live(cfg_live),
        .req_valid(req_valid), .req_write(req_write),
        .cfg_err(cfg_err), .req_ready(req_ready), .accept(accept),
        .active(active), .write_q(write_q), .tick(tick),
        .stb_on(stb_on), .stb_off(stb_off),
        .data_at(data_at), .sample_at(sample_at), .rsp_valid(rsp_valid)
    );

    mbs_strobes u_stb (
        .clk(clk), .rst_n(rst_n), .active(active), .write_q(write_q),
        .tick(tick), .stb_on(stb_on), .stb_off(stb_off),
        .cs_n(cs_n), .adv_n(adv_n), .we_n(we_n), .oe_n(oe_n)
    );

    mbs_busmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .accept(accept), .active(active),
        .write_q(write_q), .tick(tick), .data_at(data_at),
        .sample_at(sample_at), .req_addr(req_addr), .req_wdata(req_wdata),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .rdata(rsp_rdata)
    );
endmodule

// File: tb/test_mux_bus_sequencer.sv
`timescale 1ns/1ps
module test_mux_bus_sequencer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] c_cs_on, c_cs_off, c_adv_on, c_adv_off, c_we_on, c_we_off;
    logic [4:0] c_oe_on, c_oe_off, c_data_at, c_sample_at, c_cycle, c_gap;
    logic        cfg_err, req_valid, req_write, req_ready, rsp_valid, bus_oe;
    logic [27:0] req_addr;
    logic [31:0] req_wdata, rsp_rdata, bus_out, bus_in;
    logic        cs_n, adv_n, we_n, oe_n;
    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    mux_bus_sequencer i_mux_bus_sequencer (
        .clk(clk), .rst_n(rst_n),
        .cfg_cs_on(c_cs_on), .cfg_cs_off(c_cs_off),
        .cfg_adv_on(c_adv_on), .cfg_adv_off(c_adv_off),
        .cfg_we_on(c_we_on), .cfg_we_off(c_we_off),
        .cfg_oe_on(c_oe_on), .cfg_oe_off(c_oe_off),
        .cfg_data_at(c_data_at), .cfg_sample_at(c_sample_at),
        .cfg_cycle(c_cycle), .cfg_gap(c_gap), .cfg_err(cfg_err),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .bus_out(bus_out), .bus_oe(bus_oe),
        .bus_in(bus_in), .cs_n(cs_n), .adv_n(adv_n), .we_n(we_n), .oe_n(oe_n)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic set_cfg(input int cs_on, cs_off, adv_on, adv_off, we_on, we_off,
                           oe_on, oe_off, dat, smp, cyc, gap);
        c_cs_on = 5'(cs_on);  c_cs_off = 5'(cs_off);
        c_adv_on = 5'(adv_on); c_adv_off = 5'(adv_off);
        c_we_on = 5'(we_on);  c_we_off = 5'(we_off);
        c_oe_on = 5'(oe_on);  c_oe_off = 5'(oe_off);
        c_data_at = 5'(dat);  c_sample_at = 5'(smp);
        c_cycle = 5'(cyc);    c_gap = 5'(gap);
    endtask

    function automatic bit in_win(input int t, input logic [4:0] on, input logic [4:0] off);
        return (t >= int'(on)) && (t < int'(off));
    endfunction

    // One access, checked tick by tick; perturb disturbs live cfg mid-access.
    task automatic do_access(input bit wr, input logic [27:0] a, input logic [31:0] wd,
                             input logic [31:0] rd, input bit perturb);
        logic [4:0] s_cs_on, s_cs_off, s_adv_on, s_adv_off, s_we_on, s_we_off;
        logic [4:0] s_oe_on, s_oe_off, s_dat, s_smp, s_cyc;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        check(cs_n && adv_n && we_n && oe_n && !bus_oe, "R10 idle pins",
              {27'd0, cs_n, adv_n, we_n, oe_n, bus_oe}, 32'h1e);
        s_cs_on = c_cs_on; s_cs_off = c_cs_off; s_adv_on = c_adv_on; s_adv_off = c_adv_off;
        s_we_on = c_we_on; s_we_off = c_we_off; s_oe_on = c_oe_on; s_oe_off = c_oe_off;
        s_dat = c_data_at; s_smp = c_sample_at; s_cyc = c_cycle;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
        bus_in = ~rd;
        @(negedge clk);
        req_valid = 1'b0;
        for (int t = 0; t < int'(s_cyc); t++) begin
            bit e_oe;
            logic [31:0] e_bus;
            if (perturb && t == 1) begin
                c_cs_off = 5'd1; c_we_on = 5'd0; c_oe_on = 5'd0; c_data_at = 5'd0;
            end
            check(cs_n == !in_win(t, s_cs_on, s_cs_off), "R2 cs_n window", 32'(cs_n), 32'(!in_win(t, s_cs_on, s_cs_off)));
            check(adv_n == !in_win(t, s_adv_on, s_adv_off), "R2 adv_n window", 32'(adv_n), 32'(!in_win(t, s_adv_on, s_adv_off)));
            check(we_n == !(wr && in_win(t, s_we_on, s_we_off)), "R3 we_n", 32'(we_n), 32'(!(wr && in_win(t, s_we_on, s_we_off))));
            check(oe_n == !(!wr && in_win(t, s_oe_on, s_oe_off)), "R3 oe_n", 32'(oe_n), 32'(!(!wr && in_win(t, s_oe_on, s_oe_off))));
            e_oe  = wr || (t < int'(s_dat));
            e_bus = (t < int'(s_dat)) ? {4'd0, a} : wd;
            check(bus_oe == e_oe, "R4 bus_oe", 32'(bus_oe), 32'(e_oe));
            if (e_oe) check(bus_out == e_bus, "R4 bus_out", bus_out, e_bus);
            check(rsp_valid == 1'b0, "R6 no early rsp", 32'(rsp_valid), 32'd0);
            if (perturb && t == 1) check(1'b1, "R9 perturbed", 0, 0);
            bus_in = (t == int'(s_smp)) ? rd : ~rd;
            @(negedge clk);
        end
        if (perturb) begin
            c_cs_off = s_cs_off; c_we_on = s_we_on; c_oe_on = s_oe_on; c_data_at = s_dat;
        end
        check(rsp_valid == 1'b1, "R6 rsp pulse", 32'(rsp_valid), 32'd1);
        if (!wr) check(rsp_rdata == rd, "R5 read data", rsp_rdata, rd);
        @(negedge clk);
        check(rsp_valid == 1'b0, "R6 single pulse", 32'(rsp_valid), 32'd0);
    endtask

    // Held request: cs_n fall-to-fall distance must equal cycle + gap.
    task automatic measure_spacing(input int expected);
        int first, second, cyc_n;
        logic prev;
        first = -1; second = -1; prev = 1'b1;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1;
        for (cyc_n = 0; cyc_n < 80 && second < 0; cyc_n++) begin
            @(negedge clk);
            if (prev && !cs_n) begin
                if (first < 0) first = cyc_n; else second = cyc_n;
            end
            prev = cs_n;
        end
        req_valid = 1'b0;
        check(second - first == expected, "R7 start spacing", 32'(second - first), 32'(expected));
        repeat (30) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        n_tests++; n_fail++;
        $display("FAIL R7 watchdog actual=hang expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; bus_in = '0;
        set_cfg(1, 10, 2, 5, 6, 9, 6, 9, 5, 8, 11, 2);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cs_n && adv_n && we_n && oe_n, "R1 strobes high", {28'd0, cs_n, adv_n, we_n, oe_n}, 32'hf);
        check(!bus_oe && !rsp_valid && req_ready, "R1 bus/rsp/ready",
              {29'd0, bus_oe, rsp_valid, req_ready}, 32'h1);
        check(!cfg_err, "R8 default legal", 32'(cfg_err), 0);
        // Typical configuration, both directions
        do_access(1'b1, 28'h0ABCDEF, 32'hDEAD_BEEF, 32'h0, 1'b0);
        do_access(1'b0, 28'hFFFFFFF, 32'h0, 32'h1234_5678, 1'b0);
        // R9 latched configuration, disturbed ports
        do_access(1'b1, 28'h0000123, 32'hCAFE_F00D, 32'h0, 1'b1);
        do_access(1'b0, 28'h0000456, 32'h0, 32'h8765_4321, 1'b1);
        // R2 zero-length window: adv never asserts
        set_cfg(0, 7, 3, 3, 2, 6, 2, 6, 4, 6, 7, 0);
        do_access(1'b1, 28'h5, 32'h5555_AAAA, 32'h0, 1'b0);
        do_access(1'b0, 28'h6, 32'h0, 32'hA5A5_5A5A, 1'b0);
        // Sweep over cycle length, gap and direction
        for (int cyc = 3; cyc <= 8; cyc++) begin
            for (int gap = 0; gap <= 2; gap++) begin
                for (int wr = 0; wr <= 1; wr++) begin
                    set_cfg(cyc % 2, cyc, cyc % 2, cyc / 2, cyc / 2, cyc - 1, 1, cyc,
                            cyc / 2, (gap == 1) ? cyc - 1 : cyc / 2, cyc, gap);
                    do_access(wr[0], 28'(cyc * 4096 + gap), 32'(cyc * 32'h0101_0101 + gap),
                              32'(32'hF00F_0000 + cyc * 16 + gap), 1'b0);
                end
            end
        end
        // R7 spacing with and without gap
        set_cfg(1, 10, 2, 5, 6, 9, 6, 9, 5, 8, 11, 2);
        measure_spacing(13);
        set_cfg(1, 10, 2, 5, 6, 9, 6, 9, 5, 8, 11, 0);
        measure_spacing(11);
        set_cfg(1, 5, 1, 2, 2, 4, 2, 4, 2, 3, 5, 1);
        measure_spacing(6);
        // R8 illegal configurations
        set_cfg(1, 12, 2, 5, 6, 9, 6, 9, 5, 8, 11, 2);
        @(negedge clk);
        check(cfg_err, "R8 cs_off > cycle", 32'(cfg_err), 1);
        req_valid = 1'b1; req_write = 1'b1;
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            check(cs_n && we_n && !bus_oe, "R8 no start on error",
                  {29'd0, cs_n, we_n, bus_oe}, 32'h6);
        end
        req_valid = 1'b0;
        set_cfg(1, 10, 2, 5, 6, 9, 6, 9, 5, 11, 11, 2);
        @(negedge clk);
        check(cfg_err, "R8 sample_at == cycle", 32'(cfg_err), 1);
        set_cfg(1, 10, 2, 5, 6, 9, 6, 9, 12, 8, 11, 2);
        @(negedge clk);
        check(cfg_err, "R8 data_at > cycle", 32'(cfg_err), 1);
        set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        check(cfg_err, "R8 zero cycle", 32'(cfg_err), 1);
        set_cfg(1, 10, 2, 5, 6, 9, 6, 9, 5, 8, 11, 2);
        @(negedge clk);
        check(!cfg_err && req_ready, "R8 recovers", {30'd0, cfg_err, req_ready}, 32'h1);
        do_access(1'b0, 28'h7, 32'h0, 32'h0BAD_F00D, 1'b0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule